// File: doc/BRIEF.md
# Full-Duplex Serial Audio Shift Engine

This block carries stereo audio between parallel word buffers and a serial audio line, sending and receiving at the same time. Each direction has its own shift register of up to 32 bits and its own pair of buffers, one for the left channel and one for the right. A width setting selects how many bits of each word are used: 16, 24 or 32. The bit clock and the word-select line come from outside. Both are sampled into the system clock domain together with the serial input.

A word-select edge is a change in the sampled word-select level, seen on a bit-clock rising edge. After enable, nothing moves until the first valid edge, which is the one whose new level equals the chosen left-channel polarity. From then on, every word-select edge makes the transmitter load a word and makes the receiver store a word. Both start with the left buffer and then swap buffers on each edge.

Software fills the transmit buffers before it enables the transmitter. The two buffers per direction give software one channel period of slack. One-cycle strobes tell the bus-side logic which buffer was just loaded or stored. Sticky flags report a transmit buffer that was used again before it was refilled, and a receive buffer that was overwritten before it was read.

Top module: `sa_duplex_engine`

## Requirements
- R1: After reset, sd_out, both strobes, both side bits, both error flags and both receive buffers are 0.
- R2: width_sel codes 0, 1, 2 and 3 select 16, 24, 32 and 32 bits per word. The transmitter sends the low-order bits of the buffered word, most significant bit first. The receiver stores words right-justified and zero-extended.
- R3: While enabled, the transmitter makes its first load at the first valid word-select edge after tx_en rises. A valid edge is a sampled change of ws to the level ws_pol. Each load takes place on the bit-clock falling edge after the word-select edge, and sd_out then shows the word's top bit. The following bits change on each later falling edge. A non-valid edge while waiting has no effect.
- R4: Transmit loads start with the left buffer and then alternate. Each load gives a one-cycle tx_load_stb, with tx_load_right at 0 for left and 1 for right.
- R5: The receiver starts at the first valid edge after rx_en rises and samples sd_in on each later bit-clock rising edge. At every later word-select edge it stores the last chosen-width bits, including the bit sampled at that edge. Stores start with the left buffer and then alternate. Each store gives a one-cycle rx_store_stb, with rx_store_right at 0 for left and 1 for right.
- R6: A load from a transmit buffer that has not been written (tx_wr_left or tx_wr_right) since its previous load sets tx_underflow. The flag stays set until tx_en is low.
- R7: A store into a receive buffer that has not been read (rx_rd_left or rx_rd_right) since its previous store sets rx_overflow. The word is still written. The flag stays set until rx_en is low.
- R8: One cycle after tx_en goes low, sd_out is 0 and no loads occur. Re-enabling waits for a new valid edge and starts on the left again. rx_en low likewise stops the receiver.
- R9: Both directions run at once. With sd_in tied to sd_out and both directions enabled together, the receive buffers get back the transmitted left and right words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | External bit clock |
| ws | input | 1 | External word-select |
| sd_in | input | 1 | Serial receive data |
| sd_out | output | 1 | Serial transmit data |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| ws_pol | input | 1 | Word-select level that marks the left channel |
| width_sel | input | 2 | Channel width code |
| tx_wdata | input | 32 | Transmit buffer write data |
| tx_wr_left | input | 1 | Write left transmit buffer |
| tx_wr_right | input | 1 | Write right transmit buffer |
| tx_load_stb | output | 1 | Transmit load strobe |
| tx_load_right | output | 1 | Buffer used by the last load (1 = right) |
| tx_underflow | output | 1 | Sticky transmit underflow |
| rx_left_q | output | 32 | Left receive buffer |
| rx_right_q | output | 32 | Right receive buffer |
| rx_rd_left | input | 1 | Left receive buffer was read |
| rx_rd_right | input | 1 | Right receive buffer was read |
| rx_store_stb | output | 1 | Receive store strobe |
| rx_store_right | output | 1 | Buffer used by the last store (1 = right) |
| rx_overflow | output | 1 | Sticky receive overflow |

## Verification
The assertions check, on every cycle, the rules that hold in any sequence:
- loads occur only on falling edges and only while enabled;
- loads and stores start on the left after enable and then alternate;
- each error flag rises only together with a load or store strobe, and it holds while enabled;
- the line goes quiet one cycle after the transmitter is disabled.

Only the bench scenarios can show the data itself. These cover:
- loopback words coming back intact at every width code and both polarities;
- a non-valid first edge being ignored;
- the first transmitted bit being the top bit;
- the exact load on which underflow appears and the exact store on which overflow appears.

// File: rtl/sa_duplex_pkg.sv
package sa_duplex_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // width code: 0 -> 16, 1 -> 24, 2/3 -> 32
  function automatic logic [5:0] chan_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd16;
      2'd1:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic word_t word_mask(input logic [1:0] sel);
    word_t ones;
    ones = '1;
    return ones >> (WORD_W - chan_bits(sel));
  endfunction

  // move the active low-order field up to the top of the shift register
  function automatic word_t msb_align(input word_t w, input logic [1:0] sel);
    return w << (WORD_W - chan_bits(sel));
  endfunction
endpackage

// File: rtl/sa_sync.sv
module sa_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sa_ws_detect.sv
module sa_ws_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_rise,
  input  logic ws_lvl,
  input  logic ws_pol,
  output logic ws_edge,
  output logic ws_valid
);
  logic ws_q;
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q   <= 1'b0;
      seen_q <= 1'b0;
    end else if (sck_rise) begin
      ws_q   <= ws_lvl;
      seen_q <= 1'b1;
    end
  end

  assign ws_edge  = sck_rise && seen_q && (ws_lvl != ws_q);
  assign ws_valid = ws_edge && (ws_lvl == ws_pol);
endmodule

// File: rtl/sa_tx_path.sv
module sa_tx_path
  import sa_duplex_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] width_sel,
  input  logic       sck_fall,
  input  logic       ws_edge,
  input  logic       ws_valid,
  input  word_t      wdata,
  input  logic [1:0] wr,          // [0] left, [1] right
  output logic       sd,
  output logic       load_now,
  output logic       load_stb,
  output logic       load_right,
  output logic       underflow
);
  word_t      buf_q  [2];
  logic [1:0] full_q;
  word_t      shreg;
  logic       active_q, pend_q, side_q;

  assign load_now = en && active_q && pend_q && sck_fall;

  for (genvar i = 0; i < 2; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_q[i]  <= '0;
        full_q[i] <= 1'b0;
      end else if (wr[i]) begin
        buf_q[i]  <= wdata;
        full_q[i] <= 1'b1;
      end else if (load_now && (side_q == 1'(i))) begin
        full_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      pend_q     <= 1'b0;
      side_q     <= 1'b0;
      shreg      <= '0;
      load_stb   <= 1'b0;
      load_right <= 1'b0;
      underflow  <= 1'b0;
    end else begin
      load_stb <= 1'b0;
      if (!en) begin
        active_q  <= 1'b0;
        pend_q    <= 1'b0;
        underflow <= 1'b0;
      end else begin
        if (ws_edge) begin
          if (active_q) begin
            pend_q <= 1'b1;
          end else if (ws_valid) begin
            active_q <= 1'b1;
            pend_q   <= 1'b1;
            side_q   <= 1'b0;
          end
        end
        if (load_now) begin
          shreg      <= msb_align(buf_q[side_q], width_sel);
          load_stb   <= 1'b1;
          load_right <= side_q;
          side_q     <= ~side_q;
          pend_q     <= 1'b0;
          if (!full_q[side_q]) underflow <= 1'b1;
        end else if (active_q && sck_fall) begin
          shreg <= {shreg[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sd = active_q & shreg[WORD_W-1];
endmodule

// File: rtl/sa_rx_path.sv
module sa_rx_path
  import sa_duplex_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] width_sel,
  input  logic       sck_rise,
  input  logic       ws_edge,
  input  logic       ws_valid,
  input  logic       sd,
  input  logic [1:0] rd,          // [0] left, [1] right
  output word_t      left_q,
  output word_t      right_q,
  output logic       store_now,
  output logic       store_stb,
  output logic       store_right,
  output logic       overflow
);
  word_t               buf_q [2];
  logic [1:0]          unread_q;
  logic [WORD_W-2:0]   acc_q;
  word_t               acc_next;
  logic                active_q, side_q;

  assign acc_next  = {acc_q, sd};
  assign store_now = en && active_q && sck_rise && ws_edge;

  for (genvar i = 0; i < 2; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_q[i]    <= '0;
        unread_q[i] <= 1'b0;
      end else if (store_now && (side_q == 1'(i))) begin
        buf_q[i]    <= acc_next & word_mask(width_sel);
        unread_q[i] <= 1'b1;
      end else if (rd[i]) begin
        unread_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      side_q      <= 1'b0;
      acc_q       <= '0;
      store_stb   <= 1'b0;
      store_right <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      store_stb <= 1'b0;
      if (!en) begin
        active_q <= 1'b0;
        overflow <= 1'b0;
      end else if (!active_q) begin
        if (ws_valid) begin
          active_q <= 1'b1;
          side_q   <= 1'b0;
          acc_q    <= '0;
        end
      end else if (store_now) begin
        store_stb   <= 1'b1;
        store_right <= side_q;
        side_q      <= ~side_q;
        acc_q       <= '0;
        if (unread_q[side_q]) overflow <= 1'b1;
      end else if (sck_rise) begin
        acc_q <= acc_next[WORD_W-2:0];
      end
    end
  end

  assign left_q  = buf_q[0];
  assign right_q = buf_q[1];
endmodule

// File: rtl/sa_duplex_engine.sv
module sa_duplex_engine
  import sa_duplex_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck,
  input  logic        ws,
  input  logic        sd_in,
  output logic        sd_out,
  input  logic        tx_en,
  input  logic        rx_en,
  input  logic        ws_pol,
  input  logic [1:0]  width_sel,
  input  logic [31:0] tx_wdata,
  input  logic        tx_wr_left,
  input  logic        tx_wr_right,
  output logic        tx_load_stb,
  output logic        tx_load_right,
  output logic        tx_underflow,
  output logic [31:0] rx_left_q,
  output logic [31:0] rx_right_q,
  input  logic        rx_rd_left,
  input  logic        rx_rd_right,
  output logic        rx_store_stb,
  output logic        rx_store_right,
  output logic        rx_overflow
);
  localparam int N_IN = 3;   // sck, ws, sd_in

  logic [N_IN-1:0] raw_in, syn_in;
  logic            sck_s, ws_s, sd_s, sck_d;
  logic            sck_rise, sck_fall;
  logic            ws_edge, ws_valid;
  logic            tx_load_now, rx_store_now;

  assign raw_in = {sd_in, ws, sck};

  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    sa_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in[i]), .q(syn_in[i])
    );
  end

  assign {sd_s, ws_s, sck_s} = syn_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;

  sa_ws_detect u_ws (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .ws_lvl(ws_s),
    .ws_pol(ws_pol), .ws_edge(ws_edge), .ws_valid(ws_valid)
  );

  sa_tx_path u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .width_sel(width_sel),
    .sck_fall(sck_fall), .ws_edge(ws_edge), .ws_valid(ws_valid),
    .wdata(tx_wdata), .wr({tx_wr_right, tx_wr_left}), .sd(sd_out),
    .load_now(tx_load_now), .load_stb(tx_load_stb),
    .load_right(tx_load_right), .underflow(tx_underflow)
  );

  sa_rx_path u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .width_sel(width_sel),
    .sck_rise(sck_rise), .ws_edge(ws_edge), .ws_valid(ws_valid),
    .sd(sd_s), .rd({rx_rd_right, rx_rd_left}),
    .left_q(rx_left_q), .right_q(rx_right_q),
    .store_now(rx_store_now), .store_stb(rx_store_stb),
    .store_right(rx_store_right), .overflow(rx_overflow)
  );
endmodule

// File: rtl/sa_duplex_checker.sv
module sa_duplex_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic rx_en,
  input logic sd_out,
  input logic sck_fall,
  input logic tx_load_stb,
  input logic tx_load_right,
  input logic tx_underflow,
  input logic rx_store_stb,
  input logic rx_store_right,
  input logic rx_overflow
);
  logic tx_have, tx_last, rx_have, rx_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_have <= 1'b0; tx_last <= 1'b0;
      rx_have <= 1'b0; rx_last <= 1'b0;
    end else begin
      if (tx_load_stb) begin tx_have <= 1'b1; tx_last <= tx_load_right; end
      else if (!tx_en) tx_have <= 1'b0;
      if (rx_store_stb) begin rx_have <= 1'b1; rx_last <= rx_store_right; end
      else if (!rx_en) rx_have <= 1'b0;
    end
  end

  p_load_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_stb |-> $past(sck_fall) && $past(tx_en));
  p_first_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load_stb && !tx_have) |-> !tx_load_right);
  p_tx_alternate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load_stb && tx_have) |-> (tx_load_right != tx_last));
  p_rx_first_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_store_stb && !rx_have) |-> !rx_store_right);
  p_rx_alternate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_store_stb && rx_have) |-> (rx_store_right != rx_last));
  p_store_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_store_stb |-> $past(rx_en));
  p_uflow_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_underflow) |-> tx_load_stb);
  p_uflow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_underflow && tx_en) |=> tx_underflow);
  p_oflow_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overflow) |-> rx_store_stb);
  p_oflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overflow && rx_en) |=> rx_overflow);
  p_quiet_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !sd_out);
endmodule

bind sa_duplex_engine sa_duplex_checker chk_i (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
  .sd_out(sd_out), .sck_fall(sck_fall),
  .tx_load_stb(tx_load_stb), .tx_load_right(tx_load_right),
  .tx_underflow(tx_underflow), .rx_store_stb(rx_store_stb),
  .rx_store_right(rx_store_right), .rx_overflow(rx_overflow)
);

// File: tb/sa_duplex_engine_tb_top.sv
module sa_duplex_engine_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sck = 1'b0, ws = 1'b1;
  logic        sd_in, sd_out;
  logic        tx_en = 1'b0, rx_en = 1'b0, ws_pol = 1'b0;
  logic [1:0]  width_sel = 2'd2;
  logic [31:0] tx_wdata = '0;
  logic        tx_wr_left = 1'b0, tx_wr_right = 1'b0;
  logic        rx_rd_left = 1'b0, rx_rd_right = 1'b0;
  logic        tx_load_stb, tx_load_right, tx_underflow;
  logic [31:0] rx_left_q, rx_right_q;
  logic        rx_store_stb, rx_store_right, rx_overflow;

  int  checks = 0, errors = 0;
  int  bw = 32, fcnt = 0;
  int  n_ld = 0, n_st = 0;
  bit  ld_side [64];
  bit  done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  assign sd_in = sd_out;  // loopback

  sa_duplex_engine dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .sd_in(sd_in),
    .sd_out(sd_out), .tx_en(tx_en), .rx_en(rx_en), .ws_pol(ws_pol),
    .width_sel(width_sel), .tx_wdata(tx_wdata), .tx_wr_left(tx_wr_left),
    .tx_wr_right(tx_wr_right), .tx_load_stb(tx_load_stb),
    .tx_load_right(tx_load_right), .tx_underflow(tx_underflow),
    .rx_left_q(rx_left_q), .rx_right_q(rx_right_q),
    .rx_rd_left(rx_rd_left), .rx_rd_right(rx_rd_right),
    .rx_store_stb(rx_store_stb), .rx_store_right(rx_store_right),
    .rx_overflow(rx_overflow)
  );

  // bit clock: 16 system cycles per period; ws toggles after bw falling edges
  initial begin
    forever begin
      repeat (8) @(negedge clk);
      sck = ~sck;
      if (!sck) begin
        fcnt++;
        if (fcnt >= bw) begin fcnt = 0; ws = ~ws; end
      end
    end
  end

  // strobe monitor
  initial begin
    forever begin
      @(negedge clk);
      if (tx_load_stb) begin ld_side[n_ld % 64] = tx_load_right; n_ld++; end
      if (rx_store_stb) n_st++;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_ld(int base, int n);
    while (n_ld - base < n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_st(int base, int n);
    while (n_st - base < n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_tx(bit right, logic [31:0] d);
    @(negedge clk);
    tx_wdata = d; tx_wr_left = !right; tx_wr_right = right;
    @(negedge clk);
    tx_wr_left = 1'b0; tx_wr_right = 1'b0;
  endtask

  task automatic rd_rx();
    @(negedge clk);
    rx_rd_left = 1'b1; rx_rd_right = 1'b1;
    @(negedge clk);
    rx_rd_left = 1'b0; rx_rd_right = 1'b0;
  endtask

  task automatic idle(logic [1:0] sel, int w, bit pol);
    @(negedge clk);
    tx_en = 1'b0; rx_en = 1'b0;
    repeat (4) @(negedge clk);
    width_sel = sel; bw = w; ws_pol = pol;
  endtask

  function automatic logic [31:0] mask_of(int w);
    return 32'hFFFF_FFFF >> (32 - w);
  endfunction

  task automatic t_reset();
    chk("R1", "sd_out", {31'b0, sd_out}, 32'h0);
    chk("R1", "strobes", {30'b0, tx_load_stb, rx_store_stb}, 32'h0);
    chk("R1", "sides", {30'b0, tx_load_right, rx_store_right}, 32'h0);
    chk("R1", "flags", {30'b0, tx_underflow, rx_overflow}, 32'h0);
    chk("R1", "rx_left_q", rx_left_q, 32'h0);
    chk("R1", "rx_right_q", rx_right_q, 32'h0);
  endtask

  // R9 loopback at a given width code and polarity
  task automatic t_loop(logic [1:0] sel, int w, bit pol, logic [31:0] a, logic [31:0] b);
    int bl, bs;
    idle(sel, w, pol);
    rd_rx();
    wr_tx(1'b0, a);
    wr_tx(1'b1, b);
    @(negedge clk);
    bl = n_ld; bs = n_st;
    tx_en = 1'b1; rx_en = 1'b1;
    wait_st(bs, 2);
    chk("R9", "loop left word", rx_left_q, a & mask_of(w));
    chk("R2", "loop right word", rx_right_q, b & mask_of(w));
    chk("R4", "loads before second store", n_ld - bl, 2);
    chk("R4", "first load side", {31'b0, ld_side[bl % 64]}, 32'h0);
    chk("R4", "second load side", {31'b0, ld_side[(bl + 1) % 64]}, 32'h1);
    chk("R6", "no underflow when filled", {31'b0, tx_underflow}, 32'h0);
    chk("R7", "no overflow when read", {31'b0, rx_overflow}, 32'h0);
    tx_en = 1'b0; rx_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8", "sd_out after disable", {31'b0, sd_out}, 32'h0);
  endtask

  // R3: a non-valid first edge is ignored; the first bit is the word's top bit
  task automatic t_invalid_edge();
    int bl;
    idle(2'd0, 16, 1'b0);
    wr_tx(1'b0, 32'h0000_8001);
    wr_tx(1'b1, 32'h0000_1234);
    while (ws !== 1'b0) @(negedge clk);
    repeat (30) @(negedge clk);
    bl = n_ld;
    tx_en = 1'b1;
    while (ws !== 1'b1) @(negedge clk);
    repeat (30) @(negedge clk);
    chk("R3", "no load on rising ws", n_ld - bl, 0);
    chk("R3", "line idle while waiting", {31'b0, sd_out}, 32'h0);
    while (ws !== 1'b0) @(negedge clk);
    repeat (25) @(negedge clk);
    chk("R3", "one load after valid edge", n_ld - bl, 1);
    chk("R4", "that load is left", {31'b0, ld_side[bl % 64]}, 32'h0);
    chk("R2", "first bit is bit 15", {31'b0, sd_out}, 32'h1);
    repeat (15) @(negedge clk);
    chk("R3", "next bit after falling edge", {31'b0, sd_out}, 32'h0);
    tx_en = 1'b0;
  endtask

  task automatic t_underflow();
    int bl;
    idle(2'd0, 16, 1'b0);
    wr_tx(1'b0, 32'h0000_00F0);
    @(negedge clk);
    bl = n_ld;
    tx_en = 1'b1;
    wait_ld(bl, 1);
    chk("R6", "no underflow on filled left", {31'b0, tx_underflow}, 32'h0);
    wait_ld(bl, 3);
    chk("R6", "underflow on stale left", {31'b0, tx_underflow}, 32'h1);
    wr_tx(1'b0, 32'h0000_0001);
    chk("R6", "underflow stays after refill", {31'b0, tx_underflow}, 32'h1);
    tx_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8", "underflow cleared by disable", {31'b0, tx_underflow}, 32'h0);
  endtask

  task automatic t_overflow();
    int bs;
    idle(2'd0, 16, 1'b0);
    rd_rx();
    @(negedge clk);
    bs = n_st;
    rx_en = 1'b1;
    wait_st(bs, 2);
    chk("R7", "no overflow on first pair", {31'b0, rx_overflow}, 32'h0);
    wait_st(bs, 3);
    chk("R7", "overflow on unread left", {31'b0, rx_overflow}, 32'h1);
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7", "overflow cleared by disable", {31'b0, rx_overflow}, 32'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_loop(2'd2, 32, 1'b0, 32'hA5C3_0F96, 32'h1234_5678);
    t_loop(2'd1, 24, 1'b0, 32'hFFC3_0F96, 32'h00AB_CDEF);
    t_loop(2'd0, 16, 1'b1, 32'h7777_8421, 32'h0000_BEEF);
    t_loop(2'd3, 32, 1'b1, 32'h8000_0001, 32'hDEAD_BEEF);
    t_invalid_edge();
    t_underflow();
    t_overflow();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL all watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule